// File: doc/BRIEF.md
# Floppy Read-Data Separator

This block recovers a bit-cell timing reference from the raw read pulses of a floppy drive. The read input is not related to the local clock. It is brought in through a two-stage synchroniser, and each rising edge becomes a single one-clock event. A phase counter runs from 0 to period-1 and defines the recovered bit cell. Every pulse pulls that counter part of the way toward the expected position. A separate integrator adds up the measured errors over many pulses and retunes the cell length, so that cells without a pulse keep the speed learned from earlier pulses.

Each cell is split into a central data window and a surrounding clock region. At the end of every cell the block issues a one-clock strobe. The strobe carries a data sample (a pulse landed in the window) and a clock sample (a pulse landed outside it). A lock flag reports when the loop has tracked the stream accurately for a run of cells. A data-rate select stretches the cell by a power of two, so one oversampling clock serves every rate up to 2 Mbps.

The window follows a two-state machine. `WIN_CLOCK` moves to `WIN_DATA` (transition ENTER_DATA) when the next phase falls inside the window. `WIN_DATA` moves back (transition LEAVE_DATA) when the next phase leaves it. The lock tracker is a second two-state machine. `LK_SEARCH` moves to `LK_HELD` (ACQUIRE) after enough good cells. `LK_HELD` returns to `LK_SEARCH` (DROP) after enough bad cells. Each state holds itself otherwise.

Top module: `fdd_data_separator`

## Requirements
- R1: With no read pulses and rate select 0, the valid strobe repeats every 12 clocks.
- R2: Rate select value s advances the phase counter once every 2^s clocks. The cell with no pulses is therefore 12*2^s clocks long (24 for s=1, 48 for s=2).
- R3: The read input passes two synchronising flops before rising-edge detection. An input held high for many clocks counts as exactly one pulse.
- R4: A pulse whose phase p lies in [P/2-P/4, P/2+P/4) sets the data sample. Any other pulse sets the clock sample. P is the current period, and the divisions are integer divisions. Both samples are 0 except during the valid strobe, and a cell with no pulse reports both as 0.
- R5: Each pulse moves the phase toward its target by half the measured error, rounded away from zero. The target is P/2 for a data pulse and the cell edge for a clock pulse.
- R6: The integrator adds the errors. A running sum of +4 or more lengthens the period by one clock and clears the sum. A sum of -4 or less shortens the period by one clock and clears the sum. Pulse trains spaced 13 or 11 clocks apart end with a period of 13 or 11 clocks.
- R7: The period stays within 11 to 13 clocks. A train spaced 14 clocks apart leaves it at 13.
- R8: The period changes only at a cell boundary. Cells without pulses keep the last tracked period.
- R9: The data-window output is high while the phase is in the data window and low during the valid strobe. At a period of 12 it is high for 6 clocks per cell.
- R10: Lock asserts after 16 consecutive cells that each hold at least one pulse and whose largest absolute error is at most 1. Cells without a pulse neither advance nor break the count, and they do not affect lock.
- R11: Lock deasserts after 8 consecutive pulse-bearing cells whose error exceeds 1. Fewer than 8 such cells keep it asserted.
- R12: Reset sets the period to 12, clears lock and holds every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Cell stretch exponent (divide by 2^rate_sel) |
| rd_raw | input | 1 | Asynchronous read pulse from the drive, active high |
| win_o | output | 1 | Recovered data window |
| data_o | output | 1 | Data sample, valid with valid_o |
| clkbit_o | output | 1 | Clock sample, valid with valid_o |
| valid_o | output | 1 | One-clock strobe at each cell end |
| locked_o | output | 1 | Loop lock indicator |

## Verification
Evenly spaced trains at 12, 13 and 11 clocks drive the loop. Each train is followed by a quiet gap, and the cell length measured in the gap shows whether the integrator settled on the matching period or stayed at nominal. A train at 14 clocks shows that the clamp holds the period at 13. A train alternating between 9 and 15 clocks gives large errors, which separates the unlock count from the lock count. A read input held high for many clocks, and cells with no pulse, show that one edge gives one event and that empty cells report no sample.

// File: rtl/dsep_pkg.sv
package dsep_pkg;
    typedef enum logic {
        WIN_CLOCK = 1'b0,
        WIN_DATA  = 1'b1
    } win_state_t;

    typedef enum logic {
        LK_SEARCH = 1'b0,
        LK_HELD   = 1'b1
    } lock_state_t;
endpackage

// File: rtl/dsep_sync.sv
module dsep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_o
);
    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    always_comb edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o); // R3
endmodule

// File: rtl/dsep_loop.sv
module dsep_loop
    import dsep_pkg::*;
#(
    parameter int NOM     = 12,
    parameter int CLAMP   = 1,
    parameter int ACC_LIM = 4,
    parameter int RATE_W  = 2,
    localparam int PMAX   = NOM + CLAMP,
    localparam int PMIN   = NOM - CLAMP,
    localparam int EW     = $clog2(2 * PMAX + 2) + 2,
    localparam int SHMAX  = (1 << RATE_W) - 1,
    localparam int DW     = (SHMAX > 0) ? SHMAX : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              ev,
    output logic              win_o,
    output logic              valid_o,
    output logic              data_o,
    output logic              clkb_o,
    output logic              cell_end_o,
    output logic              cell_pulse_o,
    output logic [EW-1:0]     cell_err_o
);
    typedef logic signed [EW-1:0] sv_t;

    logic [DW-1:0] div_q;
    logic [DW:0]   one_sh, lim_w;
    logic          pend_q, tick, pulse;
    sv_t           ph_q, period_q, tgt_q, acc_q, maxe_q;
    logic          dseen_q, cseen_q;
    win_state_t    win_q, win_nx;
    logic          valid_q, data_q, clkb_q;

    sv_t  center, quarter, lo, hi, err, mag, cmag, corr, ph_adv, ph_nx;
    sv_t  acc_sum, acc_nx, tgt_nx, period_nx, maxe_n, lo_n, hi_n;
    logic in_data, cell_end, dseen_n, cseen_n, wd_n;

    // rate divider: one phase step every 2^rate_sel clocks
    always_comb begin
        one_sh = {{DW{1'b0}}, 1'b1} << rate_sel;
        lim_w  = one_sh - 1'b1;
        tick   = (div_q >= lim_w[DW-1:0]);
        pulse  = tick & (pend_q | ev);
    end

    // phase error and proportional correction
    always_comb begin
        center  = period_q >>> 1;
        quarter = period_q >>> 2;
        lo      = center - quarter;
        hi      = center + quarter;
        in_data = (ph_q >= lo) && (ph_q < hi);
        if (in_data)          err = ph_q - center;
        else if (ph_q < center) err = ph_q;
        else                  err = ph_q - period_q;
        mag  = (err < 0) ? -err : err;
        cmag = (mag + sv_t'(1)) >>> 1;
        corr = (err < 0) ? -cmag : cmag;
        ph_adv   = ph_q + sv_t'(1) - (pulse ? corr : sv_t'(0));
        cell_end = tick && (ph_adv >= period_q);
        if (!tick)         ph_nx = ph_q;
        else if (cell_end) ph_nx = ph_adv - period_q;
        else               ph_nx = ph_adv;
    end

    // speed integrator with clamped target period
    always_comb begin
        acc_sum = acc_q + err;
        acc_nx  = acc_q;
        tgt_nx  = tgt_q;
        if (pulse) begin
            if (acc_sum >= sv_t'(ACC_LIM)) begin
                acc_nx = '0;
                if (tgt_q < sv_t'(PMAX)) tgt_nx = tgt_q + sv_t'(1);
            end else if (acc_sum <= -sv_t'(ACC_LIM)) begin
                acc_nx = '0;
                if (tgt_q > sv_t'(PMIN)) tgt_nx = tgt_q - sv_t'(1);
            end else begin
                acc_nx = acc_sum;
            end
        end
        period_nx = cell_end ? tgt_nx : period_q;
    end

    // per-cell sample collection
    always_comb begin
        dseen_n = dseen_q | (pulse & in_data);
        cseen_n = cseen_q | (pulse & ~in_data);
        maxe_n  = (pulse && (mag > maxe_q)) ? mag : maxe_q;
    end

    // window state machine: next state
    always_comb begin
        lo_n = (period_nx >>> 1) - (period_nx >>> 2);
        hi_n = (period_nx >>> 1) + (period_nx >>> 2);
        wd_n = (ph_nx >= lo_n) && (ph_nx < hi_n);
        unique case (win_q)
            WIN_CLOCK: win_nx = wd_n ? WIN_DATA : WIN_CLOCK;   // ENTER_DATA
            WIN_DATA:  win_nx = wd_n ? WIN_DATA : WIN_CLOCK;   // LEAVE_DATA
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q    <= '0;
            pend_q   <= 1'b0;
            ph_q     <= '0;
            period_q <= sv_t'(NOM);
            tgt_q    <= sv_t'(NOM);
            acc_q    <= '0;
            maxe_q   <= '0;
            dseen_q  <= 1'b0;
            cseen_q  <= 1'b0;
            win_q    <= WIN_CLOCK;
        end else begin
            div_q    <= tick ? '0 : div_q + 1'b1;
            pend_q   <= tick ? 1'b0 : (pend_q | ev);
            ph_q     <= ph_nx;
            period_q <= period_nx;
            tgt_q    <= tgt_nx;
            acc_q    <= acc_nx;
            maxe_q   <= cell_end ? '0 : maxe_n;
            dseen_q  <= cell_end ? 1'b0 : dseen_n;
            cseen_q  <= cell_end ? 1'b0 : cseen_n;
            win_q    <= win_nx;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= 1'b0;
            clkb_q  <= 1'b0;
        end else begin
            valid_q <= cell_end;
            data_q  <= cell_end & dseen_n;
            clkb_q  <= cell_end & cseen_n;
        end
    end

    always_comb begin
        win_o        = (win_q == WIN_DATA);
        valid_o      = valid_q;
        data_o       = data_q;
        clkb_o       = clkb_q;
        cell_end_o   = cell_end;
        cell_pulse_o = dseen_n | cseen_n;
        cell_err_o   = maxe_n;
    end

    AST_PERIOD_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        (period_q >= sv_t'(PMIN)) && (period_q <= sv_t'(PMAX))); // R7
    AST_PERIOD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (period_q != $past(period_q)) |-> $past(cell_end)); // R8
    AST_STROBE_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (win_q == WIN_CLOCK)); // R9
    AST_QUIET_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> !(data_q || clkb_q)); // R4
endmodule

// File: rtl/dsep_lock.sv
module dsep_lock
    import dsep_pkg::*;
#(
    parameter int LOCK_N = 16,
    parameter int DROP_N = 8,
    parameter int TOL    = 1,
    parameter int EW     = 7,
    localparam int CW    = $clog2(LOCK_N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cell_end,
    input  logic          cell_pulse,
    input  logic [EW-1:0] cell_err,
    output logic          locked_o
);
    lock_state_t st_q, st_nx;
    logic [CW-1:0] good_q, good_nx, bad_q, bad_nx;
    logic          scored, good_cell;

    always_comb begin
        scored    = cell_end && cell_pulse;
        good_cell = (cell_err <= EW'(TOL));
        st_nx     = st_q;
        good_nx   = good_q;
        bad_nx    = bad_q;
        unique case (st_q)
            LK_SEARCH: if (scored) begin
                if (!good_cell) begin
                    good_nx = '0;
                end else if (good_q == CW'(LOCK_N - 1)) begin
                    st_nx   = LK_HELD;                  // ACQUIRE
                    good_nx = '0;
                    bad_nx  = '0;
                end else begin
                    good_nx = good_q + 1'b1;
                end
            end
            LK_HELD: if (scored) begin
                if (good_cell) begin
                    bad_nx = '0;
                end else if (bad_q == CW'(DROP_N - 1)) begin
                    st_nx   = LK_SEARCH;                // DROP
                    good_nx = '0;
                    bad_nx  = '0;
                end else begin
                    bad_nx = bad_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LK_SEARCH;
            good_q <= '0;
            bad_q  <= '0;
        end else begin
            st_q   <= st_nx;
            good_q <= good_nx;
            bad_q  <= bad_nx;
        end
    end

    always_comb locked_o = (st_q == LK_HELD);

    AST_LOCK_AT_CELL: assert property (@(posedge clk) disable iff (rst)
        (st_q != $past(st_q)) |-> $past(scored)); // R10
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (good_q < CW'(LOCK_N)) && (bad_q < CW'(DROP_N))); // R11
endmodule

// File: rtl/fdd_data_separator.sv
module fdd_data_separator #(
    parameter int NOM     = 12,
    parameter int CLAMP   = 1,
    parameter int ACC_LIM = 4,
    parameter int RATE_W  = 2,
    parameter int LOCK_N  = 16,
    parameter int DROP_N  = 8,
    parameter int TOL     = 1,
    localparam int EW     = $clog2(2 * (NOM + CLAMP) + 2) + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              rd_raw,
    output logic              win_o,
    output logic              data_o,
    output logic              clkbit_o,
    output logic              valid_o,
    output logic              locked_o
);
    logic          ev;
    logic          cell_end, cell_pulse;
    logic [EW-1:0] cell_err;

    dsep_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (rd_raw),
        .edge_o (ev)
    );

    dsep_loop #(
        .NOM(NOM), .CLAMP(CLAMP), .ACC_LIM(ACC_LIM), .RATE_W(RATE_W)
    ) u_loop (
        .clk          (clk),
        .rst          (rst),
        .rate_sel     (rate_sel),
        .ev           (ev),
        .win_o        (win_o),
        .valid_o      (valid_o),
        .data_o       (data_o),
        .clkb_o       (clkbit_o),
        .cell_end_o   (cell_end),
        .cell_pulse_o (cell_pulse),
        .cell_err_o   (cell_err)
    );

    dsep_lock #(
        .LOCK_N(LOCK_N), .DROP_N(DROP_N), .TOL(TOL), .EW(EW)
    ) u_lock (
        .clk        (clk),
        .rst        (rst),
        .cell_end   (cell_end),
        .cell_pulse (cell_pulse),
        .cell_err   (cell_err),
        .locked_o   (locked_o)
    );
endmodule

// File: tb/fdd_data_separator_tb_top.sv
`timescale 1ns/1ps
module fdd_data_separator_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rate_sel = 2'd0;
    logic       rd_raw = 1'b0;
    logic       win_o, data_o, clkbit_o, valid_o, locked_o;

    int total = 0;
    int bad = 0;
    int nv = 0, nd = 0, nc = 0, nboth = 0;
    bit done = 1'b0;

    // {pulse spacing, pulse count, expected period}
    localparam int VEC [3][3] = '{'{12, 40, 12}, '{13, 48, 13}, '{11, 48, 11}};

    always #4 clk = ~clk;

    fdd_data_separator dut_i (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .rd_raw(rd_raw),
        .win_o(win_o), .data_o(data_o), .clkbit_o(clkbit_o),
        .valid_o(valid_o), .locked_o(locked_o)
    );

    always @(negedge clk) begin
        if (!rst && valid_o) begin
            nv++;
            if (data_o) nd++;
            if (clkbit_o) nc++;
            if (data_o && clkbit_o) nboth++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rd_raw = 1'b0;
        idle(4);
        chk(!locked_o && !valid_o && !data_o && !clkbit_o && !win_o, "R12 reset outputs",
            {locked_o, valid_o, data_o, clkbit_o, win_o}, 0);
        rst = 1'b0;
    endtask

    task automatic send(input int sp, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rd_raw = 1'b1;
            @(negedge clk); rd_raw = 1'b0;
            idle(sp - 2);
        end
    endtask

    task automatic cell_len(output int len, output int wcnt);
        do @(negedge clk); while (!valid_o);
        len = 0;
        wcnt = 0;
        do begin
            @(negedge clk);
            len++;
            if (win_o) wcnt++;
        end while (!valid_o);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int len, wc, v0, s0;
        // R12 with R1: nominal cell after reset
        do_reset();
        cell_len(len, wc);
        chk(len == 12, "R1 idle cell length", len, 12);
        chk(locked_o == 1'b0, "R12 no lock without pulses", locked_o, 0);

        // table walk: R5 R6 R10 R4 R8
        for (int r = 0; r < 3; r++) begin
            do_reset();
            send(VEC[r][0], VEC[r][1] - 10);
            v0 = nv; s0 = nd + nc;
            chk(nboth == 0, "R4 single sample per cell", nboth, 0);
            send(VEC[r][0], 10);
            chk((nd + nc - s0) == (nv - v0) && (nv - v0) >= 8, "R4 one sample per pulse cell",
                nd + nc - s0, nv - v0);
            chk(locked_o == 1'b1, "R10 R5 lock on steady train", locked_o, 1);
            idle(30);
            v0 = nv; s0 = nd + nc;
            cell_len(len, wc);
            chk(len == VEC[r][2], "R6 R8 tracked period in gap", len, VEC[r][2]);
            if (VEC[r][2] == 12) chk(wc == 6, "R9 window clocks per cell", wc, 6);
            idle(60);
            chk((nd + nc) == s0 && nv > v0, "R4 empty cells report no sample", nd + nc - s0, 0);
            chk(locked_o == 1'b1, "R10 empty cells keep lock", locked_o, 1);
        end

        // R7: clamp
        do_reset();
        send(13, 48);
        send(14, 48);
        idle(30);
        cell_len(len, wc);
        chk(len == 13, "R7 period clamped", len, 13);

        // R2: rate select
        rate_sel = 2'd1;
        do_reset();
        cell_len(len, wc);
        chk(len == 24, "R2 rate 1 cell", len, 24);
        rate_sel = 2'd2;
        do_reset();
        cell_len(len, wc);
        chk(len == 48, "R2 rate 2 cell", len, 48);
        rate_sel = 2'd0;

        // R3: held-high input counts once
        do_reset();
        send(12, 40);
        idle(40);
        s0 = nd + nc;
        @(negedge clk); rd_raw = 1'b1;
        idle(40);
        rd_raw = 1'b0;
        idle(60);
        chk((nd + nc - s0) == 1, "R3 held input one event", nd + nc - s0, 1);

        // R11: unlock after enough bad cells
        do_reset();
        send(12, 40);
        chk(locked_o == 1'b1, "R10 locked before jitter", locked_o, 1);
        for (int i = 0; i < 3; i++) begin
            send(9, 1);
            send(15, 1);
        end
        chk(locked_o == 1'b1, "R11 lock kept under 8 bad cells", locked_o, 1);
        for (int i = 0; i < 20; i++) begin
            send(9, 1);
            send(15, 1);
        end
        chk(locked_o == 1'b0, "R11 lock dropped", locked_o, 0);

        // R12: reset clears lock
        do_reset();
        send(12, 40);
        do_reset();
        chk(locked_o == 1'b0, "R12 lock cleared", locked_o, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule